// File: doc/BRIEF.md
# Two-Level Sticky Status Summary

This block keeps a set of sticky condition flags. They are grouped as eight status registers of eight bits each. Single-cycle hardware pulses set the flags. Once set, a flag stays set until the host acknowledges it.

Each status register is folded into one bit of a read-only summary register. The summary register is then folded into one top-level flag, which the host reads through an event register. The same top-level flag also appears as a port that can drive an interrupt line.

The host reaches all of these through a plain register bus with a one-cycle registered read. It clears a flag by writing a 1 to that bit of its status register. A summary bit therefore falls only after the host has acknowledged every flag beneath it, one bit at a time. The summary bits and the top flag are pure OR reductions of the stored flags, so they follow a clear with no delay.

Top module: `stsum_agg`

## Requirements
- R1: After a synchronous reset, all stored flags are 0, `summary_o` is 0x00, `sum_flag_o` is 0, and `host_rdata` and `host_rvalid` are 0.
- R2: A pulse on `set_pulse_i[r*8+b]` sets bit b of status register r. The bit stays set with no further pulse. Status register r is read at address 0x40+r.
- R3: Summary bit n is the OR of all bits of status register n. The summary is read at address 0x18 and is also driven on `summary_o`.
- R4: The top flag is the OR of the eight summary bits. It reads as bit 0 of address 0x04, with bits 7 to 1 of that address reading 0, and it is also driven on `sum_flag_o`.
- R5: A host write to address 0x40+r clears each bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R6: A summary bit stays 1 while any bit of its status register is still set, and falls only once the last set bit is acknowledged.
- R7: When a set pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: Writes to 0x18, to 0x04 and to any unmapped address change no flag. Reads of an unmapped address return 0x00.
- R9: `host_rvalid` is 1 in exactly the cycle after a cycle with `host_rd_en` high, and `host_rdata` holds the addressed value in that cycle.
- R10: A read of 0x18 or 0x04 issued in the cycle after a clearing write already shows the reduced value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse_i | input | 64 | Set pulses, one per flag, indexed register*8+bit |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data (1 = acknowledge that bit) |
| host_rdata | output | 8 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| summary_o | output | 8 | Live summary bits |
| sum_flag_o | output | 1 | Live top-level flag |

## Verification
A stored flag that is lost or stuck shows on `summary_o` and `sum_flag_o` in the very next cycle, because both are plain reductions. It also shows on the registered read one cycle after the read strobe. The bench therefore probes the summary directly after each partial acknowledge, to catch a summary that falls too early or stays up too late. It reads back each status register after writes to ignored addresses and after a simultaneous set and clear, so a wrongly decoded write or an inverted priority shows up as a changed byte on the next read.

// File: rtl/stsum_pkg.sv
package stsum_pkg;
  typedef enum logic [1:0] {
    RG_STATUS  = 2'd0,
    RG_SUMMARY = 2'd1,
    RG_EVENT   = 2'd2,
    RG_NONE    = 2'd3
  } region_t;

  function automatic region_t decode_region(
    input logic [7:0] addr,
    input logic [7:0] stat_base,
    input int         num_regs,
    input logic [7:0] summ_addr,
    input logic [7:0] evt_addr
  );
    if (addr >= stat_base && int'(addr) < int'(stat_base) + num_regs) return RG_STATUS;
    if (addr == summ_addr) return RG_SUMMARY;
    if (addr == evt_addr)  return RG_EVENT;
    return RG_NONE;
  endfunction
endpackage

// File: rtl/stsum_flag_bank.sv
module stsum_flag_bank #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 8,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] SUMM_ADDR = 8'h18,
  parameter logic [ADDR_W-1:0] EVT_ADDR  = 8'h04
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_REGS*REG_W-1:0] set_i,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [REG_W-1:0]          wdata,
  output logic [NUM_REGS*REG_W-1:0] status_o
);
  import stsum_pkg::*;
  localparam int TOTAL = NUM_REGS * REG_W;

  region_t               wr_region;
  logic [ADDR_W-1:0]     wr_index;
  logic [TOTAL-1:0]      clr_mask;
  logic [TOTAL-1:0]      status_q;

  assign wr_region = decode_region(addr, STAT_BASE, NUM_REGS, SUMM_ADDR, EVT_ADDR);
  assign wr_index  = addr - STAT_BASE;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign clr_mask[r*REG_W +: REG_W] =
      (wr_en && wr_region == RG_STATUS && int'(wr_index) == r) ? wdata : '0;

    always_ff @(posedge clk) begin
      if (rst) status_q[r*REG_W +: REG_W] <= '0;
      else     status_q[r*REG_W +: REG_W] <=
                 (status_q[r*REG_W +: REG_W] & ~clr_mask[r*REG_W +: REG_W])
                 | set_i[r*REG_W +: REG_W];
    end
  end

  assign status_o = status_q;

  p_set_sticks_r2: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    ((set_i & clr_mask) != '0) |=> ((status_q & $past(set_i & clr_mask)) == $past(set_i & clr_mask)));

  p_clear_acks_r5: assert property (@(posedge clk) disable iff (rst)
    ((clr_mask & ~set_i) != '0) |=> ((status_q & $past(clr_mask & ~set_i)) == '0));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && set_i == '0) |=> $stable(status_q));
endmodule

// File: rtl/stsum_reduce.sv
module stsum_reduce #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 8
) (
  input  logic [NUM_REGS*REG_W-1:0] status_i,
  output logic [NUM_REGS-1:0]       summary_o,
  output logic                      top_o
);
  for (genvar n = 0; n < NUM_REGS; n++) begin : g_or
    assign summary_o[n] = |status_i[n*REG_W +: REG_W];
  end
  assign top_o = |summary_o;
endmodule

// File: rtl/stsum_regif.sv
module stsum_regif #(
  parameter int NUM_REGS    = 8,
  parameter int REG_W       = 8,
  parameter int ADDR_W      = 8,
  parameter int EVT_SUM_BIT = 0,
  parameter logic [ADDR_W-1:0] STAT_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] SUMM_ADDR = 8'h18,
  parameter logic [ADDR_W-1:0] EVT_ADDR  = 8'h04
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_REGS*REG_W-1:0] status_i,
  input  logic [NUM_REGS-1:0]       summary_i,
  input  logic                      top_i,
  output logic [REG_W-1:0]          rdata_o,
  output logic                      rvalid_o
);
  import stsum_pkg::*;

  region_t           rd_region;
  logic [ADDR_W-1:0] rd_index;
  logic [REG_W-1:0]  rd_mux;
  logic [REG_W-1:0]  rdata_q;
  logic              rvalid_q;

  assign rd_region = decode_region(addr, STAT_BASE, NUM_REGS, SUMM_ADDR, EVT_ADDR);
  assign rd_index  = addr - STAT_BASE;

  always_comb begin
    rd_mux = '0;
    unique case (rd_region)
      RG_STATUS: begin
        for (int r = 0; r < NUM_REGS; r++)
          if (int'(rd_index) == r) rd_mux = status_i[r*REG_W +: REG_W];
      end
      RG_SUMMARY: rd_mux[NUM_REGS-1:0] = summary_i;
      RG_EVENT:   rd_mux[EVT_SUM_BIT]  = top_i;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_rvalid_follows_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid_q);

  p_rvalid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid_q);

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_region == RG_NONE) |=> (rdata_q == '0));
endmodule

// File: rtl/stsum_agg.sv
module stsum_agg #(
  parameter int NUM_REGS    = 8,
  parameter int REG_W       = 8,
  parameter int ADDR_W      = 8,
  parameter int EVT_SUM_BIT = 0,
  parameter logic [ADDR_W-1:0] STAT_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] SUMM_ADDR = 8'h18,
  parameter logic [ADDR_W-1:0] EVT_ADDR  = 8'h04
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_REGS*REG_W-1:0] set_pulse_i,
  input  logic                      host_wr_en,
  input  logic                      host_rd_en,
  input  logic [ADDR_W-1:0]         host_addr,
  input  logic [REG_W-1:0]          host_wdata,
  output logic [REG_W-1:0]          host_rdata,
  output logic                      host_rvalid,
  output logic [NUM_REGS-1:0]       summary_o,
  output logic                      sum_flag_o
);
  localparam int TOTAL = NUM_REGS * REG_W;

  logic [TOTAL-1:0]    status_w;
  logic [NUM_REGS-1:0] summary_w;
  logic                top_w;

  stsum_flag_bank #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W),
    .STAT_BASE(STAT_BASE), .SUMM_ADDR(SUMM_ADDR), .EVT_ADDR(EVT_ADDR)
  ) u_bank (
    .clk(clk), .rst(rst), .set_i(set_pulse_i), .wr_en(host_wr_en),
    .addr(host_addr), .wdata(host_wdata), .status_o(status_w)
  );

  stsum_reduce #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_reduce (
    .status_i(status_w), .summary_o(summary_w), .top_o(top_w)
  );

  stsum_regif #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W), .EVT_SUM_BIT(EVT_SUM_BIT),
    .STAT_BASE(STAT_BASE), .SUMM_ADDR(SUMM_ADDR), .EVT_ADDR(EVT_ADDR)
  ) u_regif (
    .clk(clk), .rst(rst), .rd_en(host_rd_en), .addr(host_addr),
    .status_i(status_w), .summary_i(summary_w), .top_i(top_w),
    .rdata_o(host_rdata), .rvalid_o(host_rvalid)
  );

  assign summary_o  = summary_w;
  assign sum_flag_o = top_w;

  // R8: a write that hits no status register leaves every flag alone
  p_ro_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && set_pulse_i == '0 &&
     (host_addr < STAT_BASE || int'(host_addr) >= int'(STAT_BASE) + NUM_REGS))
    |=> $stable(status_w));

  // R6: a summary bit may only fall on a cycle that carried a write
  p_summary_fall_needs_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (!host_wr_en) |=> ((summary_w & $past(summary_w)) == $past(summary_w)));
endmodule

// File: tb/stsum_agg_tb_top.sv
module stsum_agg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] set_pulse = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic [7:0]  summary;
  logic        sum_flag;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  stsum_agg dut_i (
    .clk(clk), .rst(rst), .set_pulse_i(set_pulse), .host_wr_en(wr_en),
    .host_rd_en(rd_en), .host_addr(addr), .host_wdata(wdata),
    .host_rdata(rdata), .host_rvalid(rvalid), .summary_o(summary), .sum_flag_o(sum_flag)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data is presented (R9)
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) check("R9 unexpected rvalid", 8'h01, 8'h00);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input logic [63:0] v);
    set_pulse = v;
    @(negedge clk);
    set_pulse = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    check("watchdog expired", 8'h01, 8'h00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 summary after reset", summary, 8'h00);
    check("R1 flag after reset", {7'd0, sum_flag}, 8'h00);
    check("R1 rdata after reset", rdata, 8'h00);
    check("R1 rvalid after reset", {7'd0, rvalid}, 8'h00);
    do_read(8'h40, 8'h00, "R1 status0 reset");
    do_read(8'h18, 8'h00, "R1 summary read reset");

    // R2/R3/R4: set reg0 bit3 and reg2 bit1
    pulse(64'd1 << 3 | 64'd1 << 17);
    do_read(8'h40, 8'h08, "R2 status0 sticky");
    do_read(8'h42, 8'h02, "R2 status2 sticky");
    do_read(8'h18, 8'h05, "R3 summary read");
    check("R3 summary port", summary, 8'h05);
    do_read(8'h04, 8'h01, "R4 event read");
    check("R4 flag port", {7'd0, sum_flag}, 8'h01);

    // R5/R6: partial acknowledges
    pulse(64'd1 << 22);
    do_read(8'h42, 8'h42, "R2 status2 two bits");
    do_write(8'h42, 8'h02);
    do_read(8'h42, 8'h40, "R5 one bit acked");
    check("R6 summary held", summary, 8'h05);
    do_write(8'h42, 8'h00);
    do_read(8'h42, 8'h40, "R5 zero write keeps");
    do_write(8'h42, 8'h40);
    do_read(8'h18, 8'h01, "R10 summary next cycle");
    check("R6 summary dropped", summary, 8'h01);

    // R8: ignored writes and unmapped reads
    do_write(8'h18, 8'hFF);
    do_write(8'h04, 8'hFF);
    do_write(8'h60, 8'hFF);
    do_write(8'h3F, 8'hFF);
    do_read(8'h40, 8'h08, "R8 status0 untouched");
    do_read(8'h18, 8'h01, "R8 summary untouched");
    do_read(8'h60, 8'h00, "R8 unmapped read");
    do_read(8'h48, 8'h00, "R8 past last status");

    // R7: set wins over clear in the same cycle
    set_pulse = 64'd1 << 3;
    do_write(8'h40, 8'h08);
    set_pulse = '0;
    do_read(8'h40, 8'h08, "R7 set wins");
    do_write(8'h40, 8'h08);
    do_read(8'h04, 8'h00, "R10 event cleared next cycle");
    check("R4 flag port cleared", {7'd0, sum_flag}, 8'h00);

    // R2/R3: every flag at once
    pulse('1);
    do_read(8'h47, 8'hFF, "R2 status7 all");
    do_read(8'h18, 8'hFF, "R3 summary all");
    do_write(8'h47, 8'h7F);
    do_read(8'h47, 8'h80, "R5 top bit kept");
    check("R6 summary bit7 held", summary, 8'hFF);
    do_write(8'h47, 8'h80);
    check("R6 summary bit7 dropped", summary, 8'h7F);
    check("R9 rvalid idle", {7'd0, rvalid}, 8'h00);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) check("R9 reads unanswered", 8'(exp_q.size()), 8'h00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule